// File: doc/BRIEF.md
# LPC Long-Wait Abort and Error Interrupt Monitor

This block sits beside the LPC host bridge cycle engine and watches the SYNC phase of each bus cycle. While a peripheral keeps answering with long-wait sync codes, a counter advances. When it reaches a software-programmed limit, the block sends a one-clock abort pulse back to the cycle engine. The abort is treated as an LPC error.

Error syncs, counter aborts and delayed-transaction timeouts are kept as sticky status bits. Software clears them by writing ones. A 2-bit routing code chooses whether an error raises NMI, SMI, SCI or nothing. A separate enable bit lets delayed timeouts raise NMI, and a write-only bit lets software force a delayed-timeout NMI.

Software reaches all of this through one 32-bit register. A write strobe carries the data, and the read data is always presented. The cycle engine supplies a strobe that marks SYNC-phase clocks, together with long-wait, error and timeout flags that are qualified by that strobe.

Top module: `lpc_wait_guard`

## Requirements
- R1: After reset the register reads 0x0000_0000 and the abort, NMI, SMI and SCI outputs are low.
- R2: Register layout. Bits 15:0 hold the wait limit. Bits 19:18 hold the routing code. Bit 20 is the timeout-NMI enable. All three are read/write. Bits 31:24, 22:21 and bit 23 always read 0, and writes to bits 31:24 and 22:21 are ignored.
- R3: The counter returns to zero on every clock without the sync strobe. It advances on each clock where the strobe and long-wait are both high. The abort output pulses for one clock, in the cycle after the clock that brings the count up to the limit. It does not fire again until a new SYNC phase.
- R4: A limit of 0 never produces an abort.
- R5: Error status (bit 17) sets on a strobed error flag or on an abort. Writing a one to bit 17 clears it.
- R6: Timeout status (bit 16) sets on a strobed timeout flag. Writing a one to bit 16 clears it.
- R7: When a write-one-to-clear and a set event fall on the same clock, the status bit stays set.
- R8: When error status goes from 0 to 1, one interrupt output pulses for one clock, in the same cycle the bit first reads 1. Routing code 00 selects NMI, 10 selects SMI, 01 selects SCI, and 11 selects none.
- R9: When timeout status goes from 0 to 1, NMI pulses if bit 20 is set. SMI pulses if the routing code is 10, and SCI pulses if it is 01.
- R10: A set event on a status bit that is already 1 produces no interrupt pulse.
- R11: A write with bit 23 at 1, while the stored bit 20 is 1, sets timeout status and pulses NMI on the next cycle. This happens even if timeout status was already set. While the stored bit 20 is 0, such a write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_vld_i | input | 1 | High on each clock of a SYNC phase |
| long_wait_i | input | 1 | Long-wait sync seen (qualified by sync_vld_i) |
| err_sync_i | input | 1 | Error sync seen (qualified by sync_vld_i) |
| dly_tmo_i | input | 1 | Delayed-transaction timeout (qualified by sync_vld_i) |
| abort_o | output | 1 | One-clock abort pulse to the cycle engine |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| nmi_o | output | 1 | NMI pulse |
| smi_o | output | 1 | SMI pulse |
| sci_o | output | 1 | SCI pulse |

## Verification
The counter assertions assume the wait limit is not rewritten in the middle of a SYNC phase. They also assume that every SYNC phase is separated from the next by at least one clock with the strobe low. The stimulus only writes the register while the strobe is low, with one exception: the single same-clock clear-versus-set case, which is driven deliberately. Phases are separated by idle clocks. Each expected pulse is queued with its cycle number and compared when the outputs change.

// File: rtl/lwg_pkg.sv
package lwg_pkg;
  localparam int REG_W     = 32;
  localparam int LIM_FLD_W = 16;
  localparam int DT_BIT    = 16;
  localparam int ERR_BIT   = 17;
  localparam int SEL_LSB   = 18;
  localparam int EN_BIT    = 20;
  localparam int FORCE_BIT = 23;

  localparam int NST    = 2;
  localparam int ST_DT  = 0;
  localparam int ST_ERR = 1;

  typedef enum logic [1:0] {
    SEL_NMI  = 2'b00,
    SEL_SCI  = 2'b01,
    SEL_SMI  = 2'b10,
    SEL_NONE = 2'b11
  } irq_sel_e;
endpackage

// File: rtl/lwg_rst_sync.sv
module lwg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lwg_wait_counter.sv
module lwg_wait_counter #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_vld_i,
  input  logic             long_wait_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             hit_o,
  output logic             abort_o
);
  localparam logic [LIM_W-1:0] CNT_MAX = '1;
  localparam logic [LIM_W-1:0] ONE     = LIM_W'(1);

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             step, sat;
  logic             abort_d;

  always_comb begin
    step    = sync_vld_i & long_wait_i;
    sat     = (cnt_q == CNT_MAX);
    cnt_en  = ~sync_vld_i | (step & ~sat);
    cnt_d   = sync_vld_i ? (cnt_q + ONE) : '0;
    hit_o   = step & (limit_i != '0) & (cnt_q == (limit_i - ONE));
    abort_d = hit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q_reset: abort_o <= 1'b0;
    else        abort_o <= abort_d;
  end

  // R3: the abort is a single-clock pulse
  a_r3_abort_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  // R3: the count is back at zero after any clock without the strobe
  a_r3_cleared_between: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_vld_i |=> (cnt_q == '0));

  // R4: a zero limit never aborts
  a_r4_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |=> !abort_o);
endmodule

// File: rtl/lwg_status.sv
module lwg_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] st_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic st_q, st_d, st_en;

    always_comb begin
      st_en  = set_i[g] | clr_i[g];
      st_d   = set_i[g];
      rise_o[g] = set_i[g] & ~st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= 1'b0;
      else if (st_en) st_q <= st_d;
    end

    assign st_o[g] = st_q;

    // R7: a set event wins over a same-clock clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> st_o[g]);

    // R5 / R6: a lone clear empties the bit
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !st_o[g]);

    // R10: a rise is only reported from a clear bit
    a_r10_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      st_o[g] |-> !rise_o[g]);
  end
endmodule

// File: rtl/lwg_irq_route.sv
module lwg_irq_route
  import lwg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     err_rise_i,
  input  logic     dt_rise_i,
  input  logic     force_i,
  input  irq_sel_e sel_i,
  input  logic     nmi_en_i,
  output logic     nmi_o,
  output logic     smi_o,
  output logic     sci_o
);
  logic nmi_d, smi_d, sci_d;
  logic any_rise;

  always_comb begin
    any_rise = err_rise_i | dt_rise_i;
    nmi_d = (err_rise_i & (sel_i == SEL_NMI)) | (dt_rise_i & nmi_en_i) | force_i;
    smi_d = any_rise & (sel_i == SEL_SMI);
    sci_d = any_rise & (sel_i == SEL_SCI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_o <= 1'b0;
      smi_o <= 1'b0;
      sci_o <= 1'b0;
    end else begin
      nmi_o <= nmi_d;
      smi_o <= smi_d;
      sci_o <= sci_d;
    end
  end

  // R8: SMI and SCI are never raised together
  a_r8_smi_sci_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(smi_o && sci_o));

  // R8 / R9: an SMI pulse follows a routing code of 10
  a_r8_smi_code: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> ($past(sel_i) == SEL_SMI));

  // R9: an SCI pulse follows a routing code of 01
  a_r9_sci_code: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> ($past(sel_i) == SEL_SCI));
endmodule

// File: rtl/lpc_wait_guard.sv
module lpc_wait_guard
  import lwg_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_vld_i,
  input  logic             long_wait_i,
  input  logic             err_sync_i,
  input  logic             dly_tmo_i,
  output logic             abort_o,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             nmi_o,
  output logic             smi_o,
  output logic             sci_o
);
  localparam int LIM_PAD = LIM_FLD_W - LIM_W;

  logic             rst_sync_n;
  logic [LIM_W-1:0] lim_q, lim_d;
  irq_sel_e         sel_q, sel_d;
  logic             en_q, en_d;
  logic             ctl_en;
  logic             force_ok;
  logic             hit;
  logic [NST-1:0]   st_set, st_clr, st_q, st_rise;
  logic             wdata_unused;

  lwg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // control field next state
  always_comb begin
    ctl_en = reg_wr_i;
    lim_d  = reg_wdata_i[LIM_W-1:0];
    sel_d  = irq_sel_e'(reg_wdata_i[SEL_LSB +: 2]);
    en_d   = reg_wdata_i[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lim_q <= '0;
      sel_q <= SEL_NMI;
      en_q  <= 1'b0;
    end else if (ctl_en) begin
      lim_q <= lim_d;
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  assign wdata_unused = ^{reg_wdata_i[REG_W-1:FORCE_BIT+1], reg_wdata_i[FORCE_BIT-1:EN_BIT+1],
                          reg_wdata_i[LIM_FLD_W-1:LIM_W], 1'b0};

  lwg_wait_counter #(.LIM_W(LIM_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sync_vld_i  (sync_vld_i),
    .long_wait_i (long_wait_i),
    .limit_i     (lim_q),
    .hit_o       (hit),
    .abort_o     (abort_o)
  );

  // status set / clear events
  always_comb begin
    force_ok        = reg_wr_i & reg_wdata_i[FORCE_BIT] & en_q;
    st_set[ST_DT]   = (sync_vld_i & dly_tmo_i) | force_ok;
    st_set[ST_ERR]  = (sync_vld_i & err_sync_i) | hit;
    st_clr[ST_DT]   = reg_wr_i & reg_wdata_i[DT_BIT];
    st_clr[ST_ERR]  = reg_wr_i & reg_wdata_i[ERR_BIT];
  end

  lwg_status #(.N(NST)) u_st (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .st_o   (st_q),
    .rise_o (st_rise)
  );

  lwg_irq_route u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .err_rise_i (st_rise[ST_ERR]),
    .dt_rise_i  (st_rise[ST_DT]),
    .force_i    (force_ok),
    .sel_i      (sel_q),
    .nmi_en_i   (en_q),
    .nmi_o      (nmi_o),
    .smi_o      (smi_o),
    .sci_o      (sci_o)
  );

  // read view
  always_comb begin
    reg_rdata_o                   = '0;
    reg_rdata_o[LIM_FLD_W-1:0]    = {{LIM_PAD{1'b0}}, lim_q};
    reg_rdata_o[DT_BIT]           = st_q[ST_DT];
    reg_rdata_o[ERR_BIT]          = st_q[ST_ERR];
    reg_rdata_o[SEL_LSB +: 2]     = sel_q;
    reg_rdata_o[EN_BIT]           = en_q;
  end

  // R11: an enabled force write pulses NMI and shows timeout status
  a_r11_force_nmi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_i && reg_wdata_i[FORCE_BIT] && en_q) |=> (nmi_o && reg_rdata_o[DT_BIT]));

  // R5: an abort always leaves error status set
  a_r5_abort_sets_err: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_o |-> reg_rdata_o[ERR_BIT]);
endmodule

// File: tb/lpc_wait_guard_test.sv
module lpc_wait_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_vld, long_wait, err_sync, dly_tmo;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        abort_o, nmi_o, smi_o, sci_o;
  logic [3:0]  seen_v;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit running = 1'b0;
  bit done    = 1'b0;

  typedef struct {
    int         at;
    logic [3:0] v;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  lpc_wait_guard uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_vld_i  (sync_vld),
    .long_wait_i (long_wait),
    .err_sync_i  (err_sync),
    .dly_tmo_i   (dly_tmo),
    .abort_o     (abort_o),
    .reg_wr_i    (reg_wr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .nmi_o       (nmi_o),
    .smi_o       (smi_o),
    .sci_o       (sci_o)
  );

  assign seen_v = {abort_o, nmi_o, smi_o, sci_o};

  // driver: one clock of stimulus, expected pulse vector {abort,nmi,smi,sci}
  task automatic tick(input logic sv, input logic lw, input logic er, input logic dt,
                      input logic wr, input logic [31:0] wd, input logic [3:0] ev,
                      input string tag);
    exp_t e;
    @(negedge clk);
    sync_vld  = sv;
    long_wait = lw;
    err_sync  = er;
    dly_tmo   = dt;
    reg_wr    = wr;
    reg_wdata = wd;
    if (ev != 4'b0000) begin
      e.at  = cyc + 1;
      e.v   = ev;
      e.tag = tag;
      expq.push_back(e);
    end
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 32'h0, 4'b0000, "");
  endtask

  task automatic wr(input logic [31:0] wd, input logic [3:0] ev, input string tag);
    tick(0, 0, 0, 0, 1, wd, ev, tag);
  endtask

  task automatic rd(input logic [31:0] expv, input string tag);
    @(negedge clk);
    sync_vld = 0; long_wait = 0; err_sync = 0; dly_tmo = 0; reg_wr = 0; reg_wdata = '0;
    checks++;
    if (reg_rdata !== expv) begin
      fails++;
      $display("FAIL %s: register read actual %h expected %h", tag, reg_rdata, expv);
    end
  endtask

  // monitor: compare pulses against the scoreboard queue
  always @(negedge clk) begin
    if (running) begin
      while (expq.size() > 0 && expq[0].at < cyc) begin
        checks++;
        fails++;
        $display("FAIL %s: pulse missing, actual 0000 expected %b at cycle %0d",
                 expq[0].tag, expq[0].v, expq[0].at);
        void'(expq.pop_front());
      end
      if (seen_v != 4'b0000) begin
        checks++;
        if (expq.size() > 0 && expq[0].at == cyc) begin
          if (seen_v !== expq[0].v) begin
            fails++;
            $display("FAIL %s: pulse vector actual %b expected %b", expq[0].tag, seen_v, expq[0].v);
          end
          void'(expq.pop_front());
        end else begin
          fails++;
          $display("FAIL R3/R8/R9/R10: unexpected pulse actual %b expected 0000 at cycle %0d",
                   seen_v, cyc);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sync_vld = 0; long_wait = 0; err_sync = 0; dly_tmo = 0;
    reg_wr = 0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    running = 1'b1;

    // R1 reset state
    rd(32'h0000_0000, "R1");
    checks++;
    if (seen_v !== 4'b0000) begin
      fails++;
      $display("FAIL R1: outputs actual %b expected 0000", seen_v);
    end

    // R2 layout; force ignored because stored enable is 0 (R11)
    wr(32'hFFFF_FFFF, 4'b0000, "R11");
    rd(32'h001C_FFFF, "R2");

    // R3 abort at limit 3, routed to NMI (R8)
    wr(32'h0000_0003, 4'b0000, "");
    rd(32'h0000_0003, "R2");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b1100, "R3");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "");
    idle();
    rd(32'h0002_0003, "R5");

    // R5 write-one-to-clear
    wr(32'h0002_0003, 4'b0000, "");
    rd(32'h0000_0003, "R5");

    // R8 SMI route, R10 no retrigger, R3 clear between phases
    wr(32'h0008_0003, 4'b0000, "");
    tick(1, 0, 1, 0, 0, 32'h0, 4'b0010, "R8");
    idle();
    tick(1, 0, 1, 0, 0, 32'h0, 4'b0000, "R10");
    idle();
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "");
    idle();
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "R3");
    tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "R3");
    idle();
    rd(32'h000A_0003, "R10");

    // R8 SCI route, then code 11 raises nothing
    wr(32'h0006_0003, 4'b0000, "");
    tick(1, 0, 1, 0, 0, 32'h0, 4'b0001, "R8");
    idle();
    wr(32'h000E_0003, 4'b0000, "");
    tick(1, 0, 1, 0, 0, 32'h0, 4'b0000, "R8");
    idle();
    rd(32'h000E_0003, "R8");

    // R4 zero limit never aborts
    wr(32'h0002_0000, 4'b0000, "");
    for (int i = 0; i < 6; i++) tick(1, 1, 0, 0, 0, 32'h0, 4'b0000, "R4");
    idle();
    rd(32'h0000_0000, "R4");

    // R6 / R9 delayed timeout routing
    wr(32'h000C_0000, 4'b0000, "");
    tick(1, 0, 0, 1, 0, 32'h0, 4'b0000, "R9");
    idle();
    rd(32'h000D_0000, "R6");
    wr(32'h001D_0000, 4'b0000, "");
    rd(32'h001C_0000, "R6");
    tick(1, 0, 0, 1, 0, 32'h0, 4'b0100, "R9");
    idle();
    wr(32'h0009_0000, 4'b0000, "");
    tick(1, 0, 0, 1, 0, 32'h0, 4'b0010, "R9");
    idle();
    rd(32'h0009_0000, "R9");

    // R7 clear and set on the same clock: bit stays set, no pulse
    tick(1, 0, 0, 1, 1, 32'h0009_0000, 4'b0000, "R7");
    idle();
    rd(32'h0009_0000, "R7");

    // R11 force NMI
    wr(32'h001D_0000, 4'b0000, "");
    rd(32'h001C_0000, "R11");
    wr(32'h009C_0000, 4'b0100, "R11");
    rd(32'h001D_0000, "R11");
    wr(32'h009C_0000, 4'b0100, "R11");
    rd(32'h001D_0000, "R11");
    wr(32'h000D_0000, 4'b0000, "");
    rd(32'h000C_0000, "R11");
    wr(32'h008C_0000, 4'b0000, "R11");
    rd(32'h000C_0000, "R11");

    repeat (4) idle();
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s: pending pulses actual %0d expected 0", expq[0].tag, expq.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule